// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This block sits between a 32-bit integer core and a word-wide data memory. For every memory instruction the core hands over, it forms the effective address by adding the base register to the sign-extended 16-bit displacement. It then works out which byte lanes of the memory word the access touches. Loads can be byte, halfword or word sized, and each narrow load comes in a signed and an unsigned form. For a load, the unit picks the addressed lane out of the word the memory returns and widens it to 32 bits. For a store, it copies the low byte or low halfword of the data register across the word and raises only the strobes of the lanes being written.

One register stage sits between the request and the memory side. A request presented with `req_valid` high is captured on a rising clock edge. The address, write data and strobes then appear on the memory outputs for the next cycle. The memory is expected to return `rd_word` in that same cycle, and the unit steers it combinationally onto `ld_result`. A halfword access on an odd address, or a word access that is not on a four-byte boundary, is flagged on `align_err` and is not carried out: no strobe rises and no load result is produced.

Top module: `lsu_lane_unit`

## Requirements
- R1: The cycle after a memory request is accepted, `mem_addr` equals `rs_val` plus bits 15:0 of `instr`, sign-extended to 32 bits.
- R2: The opcode is `instr[31:26]`. The loads are 0x20 (signed byte), 0x21 (signed halfword), 0x23 (word), 0x24 (unsigned byte) and 0x25 (unsigned halfword). The stores are 0x28 (byte), 0x29 (halfword) and 0x2b (word). A load never writes, and a store never reports a load result.
- R3: A signed byte or halfword load copies the top bit of the selected lane into all higher bits of `ld_result`. For example, a byte of 0x80 gives 0xffffff80.
- R4: An unsigned byte or halfword load fills the higher bits of `ld_result` with zeros. For example, a byte of 0x80 gives 0x00000080.
- R5: Lanes are little-endian. Address bits 1:0 = k select byte bits 8k+7:8k of `rd_word`. Address bit 1 = h selects halfword bits 16h+15:16h. A word load returns `rd_word` unchanged.
- R6: A byte store raises exactly `mem_be` bit k, where k is address bits 1:0, and drives `mem_wdata` with `rt_val[7:0]` repeated in all four lanes.
- R7: An aligned halfword store raises `mem_be` = 0b0011 when address bit 1 is 0 and 0b1100 when it is 1. It drives `mem_wdata` with `rt_val[15:0]` repeated in both halves.
- R8: An aligned word store raises `mem_be` = 0b1111 and drives `mem_wdata` = `rt_val`.
- R9: A halfword access with address bit 0 set, or a word access with address bits 1:0 not zero, sets `align_err` and forces `mem_be`, `mem_wr`, `mem_wdata`, `ld_valid` and `ld_result` to zero.
- R10: A cycle with `req_valid` low, or with an opcode outside the eight listed, is ignored. The next cycle has `out_valid`, `mem_wr`, `mem_be`, `ld_valid` and `align_err` all at zero.
- R11: While `rst_n` is low and after its release, before any request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction fields are valid this cycle |
| instr | input | 32 | Instruction word: opcode in 31:26, displacement in 15:0 |
| rs_val | input | 32 | Base register value |
| rt_val | input | 32 | Store data register value |
| rd_word | input | 32 | Memory read word for the address currently on `mem_addr` |
| out_valid | output | 1 | A memory access (possibly rejected) is on the outputs |
| mem_addr | output | 32 | Effective byte address |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_be | output | 4 | Per-byte write strobes |
| mem_wr | output | 1 | Write is being performed |
| ld_valid | output | 1 | `ld_result` holds a load value |
| ld_result | output | 32 | Selected and extended load value |
| align_err | output | 1 | Misaligned access rejected |

## Verification
The bench uses the default parameters: a 32-bit data path with four byte lanes and a 16-bit displacement. With these settings every byte offset, both halfword positions and each misaligned offset can be reached simply by choosing base and displacement values. Negative displacements that borrow across the low address bits are also covered. The chosen memory words put 0x80, 0x7f and 0x8000 patterns in the selected lanes, so sign and zero extension are exercised exactly at the sign-bit boundary.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LD_B   = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LD_H   = 6'h21;
  localparam logic [OPC_W-1:0] OPC_LD_W   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_LD_BU  = 6'h24;
  localparam logic [OPC_W-1:0] OPC_LD_HU  = 6'h25;
  localparam logic [OPC_W-1:0] OPC_ST_B   = 6'h28;
  localparam logic [OPC_W-1:0] OPC_ST_H   = 6'h29;
  localparam logic [OPC_W-1:0] OPC_ST_W   = 6'h2b;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef struct packed {
    logic  ld;
    logic  st;
    size_e size;
    logic  zext;
  } acc_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output acc_t             acc
);

  always_comb begin
    acc = '0;
    case (opcode)
      OPC_LD_B:  begin acc.ld = 1'b1; acc.size = SZ_BYTE; end
      OPC_LD_H:  begin acc.ld = 1'b1; acc.size = SZ_HALF; end
      OPC_LD_W:  begin acc.ld = 1'b1; acc.size = SZ_WORD; end
      OPC_LD_BU: begin acc.ld = 1'b1; acc.size = SZ_BYTE; acc.zext = 1'b1; end
      OPC_LD_HU: begin acc.ld = 1'b1; acc.size = SZ_HALF; acc.zext = 1'b1; end
      OPC_ST_B:  begin acc.st = 1'b1; acc.size = SZ_BYTE; end
      OPC_ST_H:  begin acc.st = 1'b1; acc.size = SZ_HALF; end
      OPC_ST_W:  begin acc.st = 1'b1; acc.size = SZ_WORD; end
      default:   acc = '0;
    endcase
  end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  size_e            size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misalign
);

  always_comb begin
    case (size)
      SZ_HALF: misalign = ofs[0];
      SZ_WORD: misalign = |ofs;
      default: misalign = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int HALVES = LANES / 2,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              is_store,
  input  size_e             size,
  input  logic              misalign,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] rt_val,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be
);

  logic [DATA_W-1:0] rep_byte;
  logic [DATA_W-1:0] rep_half;
  logic [LANES-1:0]  be_byte;
  logic [LANES-1:0]  be_half;

  for (genvar g = 0; g < LANES; g++) begin : g_rep_b
    assign rep_byte[8*g +: 8] = rt_val[7:0];
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_rep_h
    assign rep_half[16*g +: 16] = rt_val[15:0];
  end

  assign be_byte = {{(LANES-1){1'b0}}, 1'b1} << ofs;
  assign be_half = {{(LANES-2){1'b0}}, 2'b11} << {ofs[OFS_W-1:1], 1'b0};

  always_comb begin
    case (size)
      SZ_BYTE: wdata = rep_byte;
      SZ_HALF: wdata = rep_half;
      default: wdata = rt_val;
    endcase
  end

  always_comb begin
    if (!is_store || misalign) begin
      be = '0;
    end else begin
      case (size)
        SZ_BYTE: be = be_byte;
        SZ_HALF: be = be_half;
        default: be = '1;
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int HALVES = LANES / 2,
  localparam int OFS_W = $clog2(LANES)
) (
  input  size_e             size,
  input  logic              zext,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] result
);

  logic [7:0]  lane_b [LANES];
  logic [15:0] lane_h [HALVES];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_b
    assign lane_b[g] = rd_word[8*g +: 8];
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_lane_h
    assign lane_h[g] = rd_word[16*g +: 16];
  end

  assign sel_b = lane_b[ofs];
  assign sel_h = lane_h[ofs[OFS_W-1:1]];

  always_comb begin
    case (size)
      SZ_BYTE: result = zext ? {{(DATA_W-8){1'b0}}, sel_b}
                              : {{(DATA_W-8){sel_b[7]}}, sel_b};
      SZ_HALF: result = zext ? {{(DATA_W-16){1'b0}}, sel_h}
                              : {{(DATA_W-16){sel_h[15]}}, sel_h};
      default: result = rd_word;
    endcase
  end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int INSTR_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic [DATA_W-1:0]  rt_val,
  input  logic [DATA_W-1:0]  rd_word,
  output logic               out_valid,
  output logic [DATA_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [LANES-1:0]   mem_be,
  output logic               mem_wr,
  output logic               ld_valid,
  output logic [DATA_W-1:0]  ld_result,
  output logic               align_err
);

  // request side
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] ea_d;
  acc_t              acc_d;
  logic              mis_d;
  logic [DATA_W-1:0] wdata_d;
  logic [LANES-1:0]  be_d;
  logic              unused_fields;

  assign unused_fields = ^instr[INSTR_W-OPC_W-1:IMM_W];
  assign imm_ext = {{(DATA_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign ea_d    = rs_val + imm_ext;

  lsu_decode u_dec (
    .opcode (instr[INSTR_W-1 -: OPC_W]),
    .acc    (acc_d)
  );

  lsu_align #(.OFS_W(OFS_W)) u_aln (
    .size     (acc_d.size),
    .ofs      (ea_d[OFS_W-1:0]),
    .misalign (mis_d)
  );

  lsu_store_lane #(.DATA_W(DATA_W)) u_st (
    .is_store (acc_d.st),
    .size     (acc_d.size),
    .misalign (mis_d),
    .ofs      (ea_d[OFS_W-1:0]),
    .rt_val   (rt_val),
    .wdata    (wdata_d),
    .be       (be_d)
  );

  // stage registers
  logic              valid_q, valid_n;
  logic [DATA_W-1:0] addr_q,  addr_n;
  acc_t              acc_q,   acc_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic [LANES-1:0]  be_q,    be_n;
  logic              err_q,   err_n;
  logic              cap_en;

  assign cap_en = req_valid;

  always_comb begin
    valid_n = req_valid && (acc_d.ld || acc_d.st);
    addr_n  = addr_q;
    acc_n   = acc_q;
    wdata_n = wdata_q;
    be_n    = be_q;
    err_n   = err_q;
    if (cap_en) begin
      addr_n  = ea_d;
      acc_n   = acc_d;
      wdata_n = wdata_d;
      be_n    = be_d;
      err_n   = mis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      acc_q   <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_n;
      addr_q  <= addr_n;
      acc_q   <= acc_n;
      wdata_q <= wdata_n;
      be_q    <= be_n;
      err_q   <= err_n;
    end
  end

  // memory side
  logic [DATA_W-1:0] ld_raw;

  lsu_load_lane #(.DATA_W(DATA_W)) u_ld (
    .size    (acc_q.size),
    .zext    (acc_q.zext),
    .ofs     (addr_q[OFS_W-1:0]),
    .rd_word (rd_word),
    .result  (ld_raw)
  );

  assign out_valid = valid_q;
  assign mem_addr  = valid_q ? addr_q : '0;
  assign mem_wr    = valid_q && acc_q.st && !err_q;
  assign ld_valid  = valid_q && acc_q.ld && !err_q;
  assign align_err = valid_q && err_q;
  assign mem_be    = mem_wr ? be_q : '0;
  assign mem_wdata = mem_wr ? wdata_q : '0;
  assign ld_result = ld_valid ? ld_raw : '0;

endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int INSTR_W = 32,
  localparam int LANES  = DATA_W / 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  rs_val,
  input logic [DATA_W-1:0]  rt_val,
  input logic               out_valid,
  input logic [DATA_W-1:0]  mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic [LANES-1:0]   mem_be,
  input logic               mem_wr,
  input logic               ld_valid,
  input logic [DATA_W-1:0]  ld_result,
  input logic               align_err
);

  // R1: address follows the request by one cycle
  p_ea_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mem_addr == $past(rs_val +
      {{(DATA_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]}));

  // R2: write and load result never together
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && ld_valid));

  // R4: unsigned byte load leaves the upper bits clear
  p_unsigned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(instr[INSTR_W-1 -: 6] == 6'h24))
      |-> ld_result[DATA_W-1:8] == '0);

  // R6/R7/R8: a write raises one, two or all lanes
  p_strobe_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                $countones(mem_be) == LANES));

  // R8: word store passes the register through on all lanes
  p_word_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(instr[INSTR_W-1 -: 6] == 6'h2b))
      |-> (mem_be == '1 && mem_wdata == $past(rt_val)));

  // R9: a rejected access stays silent
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (mem_be == '0 && !mem_wr && !ld_valid && ld_result == '0));

  // R10: no request, no activity
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!out_valid && !mem_wr && mem_be == '0));

endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .INSTR_W(INSTR_W)
) u_chk (.*);

// File: tb/lsu_lane_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] rd_word;
  logic        out_valid;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_wr;
  logic        ld_valid;
  logic [31:0] ld_result;
  logic        align_err;

  lsu_lane_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .rd_word(rd_word),
    .out_valid(out_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_wr(mem_wr), .ld_valid(ld_valid),
    .ld_result(ld_result), .align_err(align_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string       tag;
    logic        vld;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        wr;
    logic        ldv;
    logic [31:0] res;
    logic        err;
  } item_t;

  item_t exp_q[$];
  int    n_chk;
  int    n_fail;
  logic  sampled_req;
  bit    done;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected outcome written from the requirements
  function automatic item_t model(input string tag, input logic [5:0] opc,
                                  input logic [31:0] rs, input logic [15:0] imm,
                                  input logic [31:0] rt, input logic [31:0] rdw);
    item_t       it;
    logic [31:0] ea;
    logic [1:0]  o;
    logic [7:0]  b;
    logic [15:0] h;
    ea = rs + {{16{imm[15]}}, imm};
    o  = ea[1:0];
    b  = rdw >> (8 * o);
    h  = o[1] ? rdw[31:16] : rdw[15:0];
    it.tag = tag; it.vld = 0; it.addr = 0; it.wdata = 0; it.be = 0;
    it.wr = 0; it.ldv = 0; it.res = 0; it.err = 0;
    case (opc)
      6'h20: begin it.ldv = 1; it.res = {{24{b[7]}}, b}; end
      6'h24: begin it.ldv = 1; it.res = {24'h0, b}; end
      6'h21: if (o[0]) it.err = 1; else begin it.ldv = 1; it.res = {{16{h[15]}}, h}; end
      6'h25: if (o[0]) it.err = 1; else begin it.ldv = 1; it.res = {16'h0, h}; end
      6'h23: if (o != 0) it.err = 1; else begin it.ldv = 1; it.res = rdw; end
      6'h28: begin it.wr = 1; it.be = 4'b0001 << o; it.wdata = {4{rt[7:0]}}; end
      6'h29: if (o[0]) it.err = 1;
             else begin it.wr = 1; it.be = o[1] ? 4'b1100 : 4'b0011; it.wdata = {2{rt[15:0]}}; end
      6'h2b: if (o != 0) it.err = 1; else begin it.wr = 1; it.be = 4'b1111; it.wdata = rt; end
      default: ;
    endcase
    if (opc inside {6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b}) begin
      it.vld  = 1;
      it.addr = ea;
    end
    return it;
  endfunction

  // driver: one request, then one idle cycle
  task automatic issue(input string tag, input logic [5:0] opc,
                       input logic [31:0] rs, input logic [15:0] imm,
                       input logic [31:0] rt, input logic [31:0] rdw);
    @(negedge clk);
    instr     = {opc, 5'd3, 5'd7, imm};
    rs_val    = rs;
    rt_val    = rt;
    rd_word   = rdw;
    req_valid = 1'b1;
    exp_q.push_back(model(tag, opc, rs, imm, rt, rdw));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) sampled_req <= 1'b0;
    else        sampled_req <= req_valid;

  // monitor
  always @(negedge clk) begin
    if (rst_n && sampled_req) begin
      if (exp_q.size() == 0) begin
        chk("R10", "unexpected output", {31'h0, out_valid}, 32'h0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(e.tag, "out_valid", {31'h0, out_valid}, {31'h0, e.vld});
        chk(e.tag, "mem_addr",  mem_addr,  e.addr);
        chk(e.tag, "mem_wdata", mem_wdata, e.wdata);
        chk(e.tag, "mem_be",    {28'h0, mem_be}, {28'h0, e.be});
        chk(e.tag, "mem_wr",    {31'h0, mem_wr}, {31'h0, e.wr});
        chk(e.tag, "ld_valid",  {31'h0, ld_valid}, {31'h0, e.ldv});
        chk(e.tag, "ld_result", ld_result, e.res);
        chk(e.tag, "align_err", {31'h0, align_err}, {31'h0, e.err});
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; req_valid = 1'b0; instr = '0;
    rs_val = '0; rt_val = '0; rd_word = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "out_valid", {31'h0, out_valid}, 32'h0);
    chk("R11", "mem_be", {28'h0, mem_be}, 32'h0);
    chk("R11", "ld_result", ld_result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "mem_addr after release", mem_addr, 32'h0);
    chk("R11", "align_err after release", {31'h0, align_err}, 32'h0);

    // R3 / R4: the 0x80 byte in both forms
    issue("R3 lb 0x80",  6'h20, 32'h0000_1000, 16'h0000, 32'h0, 32'h11_22_33_80);
    issue("R4 lbu 0x80", 6'h24, 32'h0000_1000, 16'h0000, 32'h0, 32'h11_22_33_80);
    // R5: every byte lane
    for (int k = 0; k < 4; k++) begin
      issue($sformatf("R5 lb lane%0d", k), 6'h20, 32'h0000_2000, 16'(k), 32'h0, 32'h80_7f_f1_0e);
      issue($sformatf("R5 lbu lane%0d", k), 6'h24, 32'h0000_2000, 16'(k), 32'h0, 32'h80_7f_f1_0e);
    end
    // R3 / R4 / R5: halfwords
    issue("R3 lh low",   6'h21, 32'h0000_3000, 16'h0000, 32'h0, 32'h7fff_8000);
    issue("R3 lh high",  6'h21, 32'h0000_3000, 16'h0002, 32'h0, 32'h8001_7fff);
    issue("R4 lhu low",  6'h25, 32'h0000_3000, 16'h0000, 32'h0, 32'h7fff_8000);
    issue("R4 lhu high", 6'h25, 32'h0000_3000, 16'h0002, 32'h0, 32'h8001_1234);
    issue("R5 lw",       6'h23, 32'h0000_3000, 16'h0004, 32'h0, 32'hdead_beef);
    // R1: negative displacement borrowing into low bits
    issue("R1 neg imm lb", 6'h20, 32'h0000_4002, 16'hfffd, 32'h0, 32'hc0_00_00_00);
    issue("R1 neg imm sw", 6'h2b, 32'h0000_4010, 16'hfff0, 32'hcafe_f00d, 32'h0);
    // R6: byte stores on each lane
    for (int k = 0; k < 4; k++)
      issue($sformatf("R6 sb lane%0d", k), 6'h28, 32'h0000_5000, 16'(k), 32'h1234_56a5, 32'h0);
    // R7: halfword stores
    issue("R7 sh low",  6'h29, 32'h0000_6000, 16'h0000, 32'hffff_8c3d, 32'h0);
    issue("R7 sh high", 6'h29, 32'h0000_6000, 16'h0002, 32'hffff_8c3d, 32'h0);
    // R8: word store
    issue("R8 sw", 6'h2b, 32'h0000_7000, 16'h0008, 32'h0bad_cafe, 32'h0);
    // R9: misaligned accesses
    issue("R9 lh odd",  6'h21, 32'h0000_8000, 16'h0001, 32'h0, 32'hffff_ffff);
    issue("R9 lhu odd", 6'h25, 32'h0000_8000, 16'h0003, 32'h0, 32'hffff_ffff);
    issue("R9 lw ofs2", 6'h23, 32'h0000_8000, 16'h0002, 32'h0, 32'hffff_ffff);
    issue("R9 sh odd",  6'h29, 32'h0000_8000, 16'h0003, 32'haaaa_aaaa, 32'h0);
    issue("R9 sw ofs1", 6'h2b, 32'h0000_8000, 16'h0001, 32'haaaa_aaaa, 32'h0);
    // R2 / R10: non-memory opcode is ignored
    issue("R10 opc 0x08", 6'h08, 32'h0000_9000, 16'h0000, 32'h5555_5555, 32'h0);
    issue("R2 opc 0x22",  6'h22, 32'h0000_9000, 16'h0000, 32'h5555_5555, 32'h0);

    // R10: store opcode with req_valid low
    @(negedge clk);
    instr = {6'h2b, 5'd3, 5'd7, 16'h0000};
    rs_val = 32'h0000_a000; rt_val = 32'hffff_ffff;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle", "out_valid", {31'h0, out_valid}, 32'h0);
    chk("R10 idle", "mem_wr", {31'h0, mem_wr}, 32'h0);
    chk("R10 idle", "mem_be", {28'h0, mem_be}, 32'h0);

    repeat (2) @(negedge clk);
    chk("R10", "scoreboard drained", exp_q.size(), 32'h0);
    done = 1;
    finish_run();
  end

endmodule